// File: doc/BRIEF.md
# Scrolling Display Line Scan Generator

This block produces the display RAM row address for each common-line period of a dot-matrix panel. For every line-clock pulse it issues one fetch request: a one-cycle `fetchValid` strobe with the row whose 128 columns are to be moved into the output latch. The host sets a start-line register that names which RAM row appears on the first common line. Rewriting that register scrolls the picture vertically without touching the RAM contents.

A frame-start pulse copies the start-line register into a row counter. Each line clock then fetches the counter's row and advances it, wrapping from the top row back to row 0. Once all main rows have been fetched, one further slot may fetch the icon row. That fetch is flagged and never takes the scroll offset. Frame timing, the RAM and the segment drivers lie outside the block. Because the block only issues row requests, it leaves host RAM traffic alone.

Top module: `line_scan_gen`

## Requirements
- R1: After reset `fetchValid`, `fetchIcon` and `fetchRow` are 0, the start-line register is 0, and line clocks before the first frame start produce no fetch.
- R2: A cycle with `startLineWe` high loads `startLineData` into the start-line register. A frame start uses the value the register held before that cycle, so a write in the same cycle as a frame start applies from the following frame.
- R3: In the cycle after the k-th line clock of a frame (k = 0..127), `fetchValid` is 1, `fetchIcon` is 0 and `fetchRow` equals (start + k) mod 128.
- R4: The row sequence wraps from 127 to 0 within a frame.
- R5: A start-line write in the middle of a frame leaves the remaining rows of that frame unchanged.
- R6: When `iconEn` is 1 at the 129th line clock of a frame, the next cycle shows `fetchValid`=1, `fetchIcon`=1 and `fetchRow`=0, whatever the start line.
- R7: When `iconEn` is 0 at the 129th line clock, no fetch occurs. Every line clock after the 129th is ignored until the next frame start.
- R8: A frame start wins over a line clock in the same cycle: no fetch results, and the frame restarts at the start line, even in the middle of a frame.
- R9: `fetchValid` lasts one cycle per accepted line clock and is 0 in the cycle after a cycle with no line clock. `fetchIcon` is 1 only together with `fetchValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLineWe | input | 1 | Start-line register write strobe |
| startLineData | input | 7 | New start line |
| iconEn | input | 1 | Enable the icon-row fetch slot |
| frameStart | input | 1 | One-cycle frame start pulse |
| lineClk | input | 1 | One-cycle line clock pulse |
| fetchValid | output | 1 | Fetch request strobe |
| fetchRow | output | 7 | RAM row to fetch |
| fetchIcon | output | 1 | Fetch targets the icon row |

## Verification
Whole frames are run with start lines 0, 1, 5, 64 and 127, and every fetched row is compared with (start + k) mod 128. Start 0 never wraps, while the high starts wrap early, which separates a correct modulo counter from one that saturates or restarts. The icon slot is run with the enable both set and cleared, and extra line clocks follow it, to show that the slot count stops exactly after 129. The write-timing cases are a write in the middle of a frame, a write in the same cycle as a frame start, and a frame start that coincides with a line clock. Together they tell the shadowed start register and the frame-start priority apart from a design that samples the register live.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef struct packed {
    logic load;      // copy start line into row counter
    logic stepMain;  // fetch current row and advance
    logic stepIcon;  // fetch icon row
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int ROW_BITS = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        lineClk,
  input  logic        iconEn,
  output scanStrobe_t strobe
);
  // slotCnt top bit set means all main rows are done
  logic [ROW_BITS:0] slotCnt;
  logic              scanning;

  always_comb begin
    strobe = '0;
    if (frameStart) begin
      strobe.load = 1'b1;
    end else if (lineClk && scanning) begin
      if (!slotCnt[ROW_BITS]) strobe.stepMain = 1'b1;
      else                    strobe.stepIcon = iconEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      scanning <= 1'b0;
    end else if (frameStart) begin
      slotCnt  <= '0;
      scanning <= 1'b1;
    end else if (lineClk && scanning) begin
      if (!slotCnt[ROW_BITS]) slotCnt  <= slotCnt + 1'b1;
      else                    scanning <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int ROW_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startLineWe,
  input  logic [ROW_BITS-1:0] startLineData,
  input  scanStrobe_t         strobe,
  output logic                fetchValid,
  output logic [ROW_BITS-1:0] fetchRow,
  output logic                fetchIcon
);
  logic [ROW_BITS-1:0] startLine;
  logic [ROW_BITS-1:0] rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) startLine <= '0;
    else if (startLineWe) startLine <= startLineData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt     <= '0;
      fetchValid <= 1'b0;
      fetchRow   <= '0;
      fetchIcon  <= 1'b0;
    end else begin
      fetchValid <= strobe.stepMain | strobe.stepIcon;
      fetchIcon  <= strobe.stepIcon;
      if (strobe.load) begin
        rowCnt <= startLine;
      end else if (strobe.stepMain) begin
        fetchRow <= rowCnt;
        rowCnt   <= rowCnt + 1'b1;
      end else if (strobe.stepIcon) begin
        fetchRow <= '0;
      end
    end
  end
endmodule

// File: rtl/line_scan_gen.sv
module line_scan_gen
  import scan_pkg::*;
#(
  parameter int ROW_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startLineWe,
  input  logic [ROW_BITS-1:0] startLineData,
  input  logic                iconEn,
  input  logic                frameStart,
  input  logic                lineClk,
  output logic                fetchValid,
  output logic [ROW_BITS-1:0] fetchRow,
  output logic                fetchIcon
);
  scanStrobe_t strobe;

  scan_ctrl #(.ROW_BITS(ROW_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .lineClk(lineClk), .iconEn(iconEn), .strobe(strobe)
  );

  scan_datapath #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .startLineWe(startLineWe),
    .startLineData(startLineData), .strobe(strobe),
    .fetchValid(fetchValid), .fetchRow(fetchRow), .fetchIcon(fetchIcon)
  );
endmodule

// File: rtl/line_scan_checker.sv
module line_scan_checker #(
  parameter int ROW_BITS = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameStart,
  input logic                lineClk,
  input logic                fetchValid,
  input logic [ROW_BITS-1:0] fetchRow,
  input logic                fetchIcon
);
  logic [ROW_BITS-1:0] lastRow;
  logic                haveLast;
  logic [ROW_BITS:0]   mainCount;

  always_ff @(posedge clk) begin
    if (!rstN || frameStart) begin
      haveLast  <= 1'b0;
      lastRow   <= '0;
      mainCount <= '0;
    end else if (fetchValid && !fetchIcon) begin
      haveLast  <= 1'b1;
      lastRow   <= fetchRow;
      mainCount <= mainCount + 1'b1;
    end
  end

  assert_icon_with_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    fetchIcon |-> fetchValid);

  assert_valid_needs_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lineClk |=> !fetchValid);

  assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !fetchValid);

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchIcon && haveLast) |-> (fetchRow == lastRow + 1'b1));

  assert_main_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchIcon) |-> !mainCount[ROW_BITS]);

  assert_icon_row_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchIcon |-> (fetchRow == '0));
endmodule

bind line_scan_gen line_scan_checker #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineClk(lineClk),
  .fetchValid(fetchValid), .fetchRow(fetchRow), .fetchIcon(fetchIcon)
);

// File: tb/line_scan_gen_bench.sv
`timescale 1ns/1ps
module line_scan_gen_bench;
  localparam int ROW_BITS = 7;
  localparam int ROWS = 1 << ROW_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startLineWe = 1'b0;
  logic [ROW_BITS-1:0] startLineData = '0;
  logic iconEn = 1'b0;
  logic frameStart = 1'b0;
  logic lineClk = 1'b0;
  logic fetchValid;
  logic [ROW_BITS-1:0] fetchRow;
  logic fetchIcon;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  line_scan_gen #(.ROW_BITS(ROW_BITS)) u_line_scan_gen (
    .clk(clk), .rstN(rstN), .startLineWe(startLineWe),
    .startLineData(startLineData), .iconEn(iconEn),
    .frameStart(frameStart), .lineClk(lineClk),
    .fetchValid(fetchValid), .fetchRow(fetchRow), .fetchIcon(fetchIcon)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeStart(input int v);
    startLineWe = 1'b1;
    startLineData = ROW_BITS'(v);
    @(negedge clk);
    startLineWe = 1'b0;
  endtask

  task automatic startFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check(!fetchValid, "R8 no fetch after frame start", int'(fetchValid), 0);
  endtask

  task automatic pulseLine();
    lineClk = 1'b1;
    @(negedge clk);
    lineClk = 1'b0;
  endtask

  task automatic expectMain(input int exp, input string req);
    check(fetchValid && !fetchIcon && int'(fetchRow) == exp, req, int'(fetchRow), exp);
  endtask

  task automatic runLines(input int first, input int from, input int count);
    for (int k = from; k < from + count; k++) begin
      int exp;
      exp = (first + k) % ROWS;
      pulseLine();
      if (first + k >= ROWS) expectMain(exp, "R4 wrapped row");
      else                   expectMain(exp, "R3 row sequence");
    end
  endtask

  task automatic finishFrame(input bit icon);
    iconEn = icon;
    pulseLine();
    if (icon)
      check(fetchValid && fetchIcon && fetchRow == '0, "R6 icon fetch", int'(fetchRow), 0);
    else
      check(!fetchValid && !fetchIcon, "R7 no icon fetch", int'(fetchValid), 0);
    iconEn = 1'b0;
    pulseLine();
    check(!fetchValid, "R7 extra line ignored", int'(fetchValid), 0);
    pulseLine();
    check(!fetchValid, "R7 extra line ignored", int'(fetchValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int starts[5] = '{0, 1, 5, 64, 127};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!fetchValid && !fetchIcon && fetchRow == '0, "R1 reset outputs", int'(fetchRow), 0);
    pulseLine();
    check(!fetchValid, "R1 no fetch before frame start", int'(fetchValid), 0);
    // R1 start register resets to 0
    startFrame();
    pulseLine();
    expectMain(0, "R1 reset start line");

    // Full frame sweep over start lines
    foreach (starts[i]) begin
      writeStart(starts[i]);
      startFrame();
      runLines(starts[i], 0, ROWS);
      finishFrame(i % 2 == 0);
    end

    // R9 single-cycle strobe
    writeStart(20);
    startFrame();
    pulseLine();
    expectMain(20, "R9 fetch present");
    @(negedge clk);
    check(!fetchValid, "R9 strobe ends", int'(fetchValid), 0);

    // R5 mid-frame write
    writeStart(10);
    startFrame();
    runLines(10, 0, 5);
    writeStart(90);
    for (int k = 5; k < ROWS; k++) begin
      pulseLine();
      expectMain((10 + k) % ROWS, "R5 mid-frame write ignored");
    end
    finishFrame(1'b1);
    // R2 new value at next frame
    startFrame();
    pulseLine();
    expectMain(90, "R2 new start applied");

    // R2 write in same cycle as frame start
    startLineWe = 1'b1;
    startLineData = 7'd33;
    frameStart = 1'b1;
    @(negedge clk);
    startLineWe = 1'b0;
    frameStart = 1'b0;
    pulseLine();
    expectMain(90, "R2 same-cycle write deferred");
    startFrame();
    pulseLine();
    expectMain(33, "R2 deferred write applied");

    // R8 frame start with line clock, mid-frame restart
    runLines(33, 1, 3);
    frameStart = 1'b1;
    lineClk = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    lineClk = 1'b0;
    check(!fetchValid, "R8 line clock dropped", int'(fetchValid), 0);
    runLines(33, 0, ROWS);
    finishFrame(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule